// File: doc/BRIEF.md
# Centred-Range Gray Pointer Counter

This block is a pointer counter for an asynchronous FIFO whose depth is even but not a power of two. Each step moves a binary value up by one across a window of `MODULUS` codes placed in the middle of a `2^W` space, where `W` is the ceiling of log2 of `MODULUS`. The window runs from `2^W/2 - MODULUS/2` to `2^W/2 + MODULUS/2 - 1`. After the last code the value returns to the first. The two ends of this window are mirror images around the midpoint of the space, so their Gray codes differ only in the top bit. Every step therefore changes exactly one Gray bit, the wrap included. This is what makes the Gray value safe to pass through a multi-flop synchronizer into another clock domain.

Along with the current value, the block provides the values one and two steps ahead, in binary and in Gray. FIFO flag logic uses these to predict empty or full one read or write early. Only the two-ahead value is incremented and wrapped. The nearer values are filled from it through a register pipeline. All Gray outputs come straight from flops. An odd modulus, a modulus below two, or a modulus that does not fit in `2^W` stops elaboration with an error.

With the default `MODULUS = 688`, `W = 10` and the window is 168 to 855.

Top module: `gray_ring_counter`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `cur_bin_o` holds the window start, `nxt_bin_o` holds start+1 and `nxt2_bin_o` holds start+2. For the default of 688 these are 168, 169 and 170, and each Gray output matches its binary value.
- R2: On a rising clock edge with `adv_i` low, none of the six outputs changes.
- R3: On a rising clock edge with `adv_i` high, `cur_bin_o` takes the old `nxt_bin_o` and `nxt_bin_o` takes the old `nxt2_bin_o`. Seen from the ports, the current value goes up by one.
- R4: Advancing from the window end (855 by default) gives the window start (168 by default).
- R5: Every binary output always lies in the window, start to end inclusive.
- R6: Each Gray output equals its binary output XOR that binary value shifted right by one, so Gray bit y is binary bit y XOR binary bit y+1 and the top bit passes straight through.
- R7: Each advance changes exactly one bit of `cur_gray_o`, including the step from window end to window start.
- R8: `nxt_bin_o` is always one step past `cur_bin_o`, and `nxt2_bin_o` is always one step past `nxt_bin_o`, where one step after the end is the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Advance the pointer by one step at this edge |
| cur_bin_o | output | W | Current pointer, binary |
| cur_gray_o | output | W | Current pointer, Gray |
| nxt_bin_o | output | W | Pointer one step ahead, binary |
| nxt_gray_o | output | W | Pointer one step ahead, Gray |
| nxt2_bin_o | output | W | Pointer two steps ahead, binary |
| nxt2_gray_o | output | W | Pointer two steps ahead, Gray |

## Verification
The assertions check the following on every cycle out of reset:
- the window bound on all three pointers;
- the Gray-to-binary agreement of each output pair;
- the one-step spacing of the lookahead values;
- holding when idle;
- the single-bit Gray change on each advance.

Only the bench's scenarios can show the rest:
- that the count follows the exact arithmetic sequence over several full laps, including wraps at the window end after uneven run lengths;
- that reset loads the window start again from the middle of a lap.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;

    // Pointer width: smallest W with 2^W >= m
    function automatic int unsigned ptr_width(input int unsigned m);
        return (m < 2) ? 1 : $clog2(m);
    endfunction

    // First code of the centred window
    function automatic int unsigned range_first(input int unsigned m);
        return (32'd1 << (ptr_width(m) - 1)) - (m / 2);
    endfunction

    // Last code of the centred window
    function automatic int unsigned range_last(input int unsigned m);
        return range_first(m) + m - 1;
    endfunction

    // One ring step inside the window
    function automatic int unsigned ring_step(input int unsigned x, input int unsigned m);
        return (x == range_last(m)) ? range_first(m) : x + 1;
    endfunction

    // Reflected binary code of a 32-bit value
    function automatic int unsigned gray32(input int unsigned x);
        return x ^ (x >> 1);
    endfunction

endpackage

// File: rtl/gcnt_step.sv
// Advances a binary code by one inside [FIRST, LAST], wrapping to FIRST
module gcnt_step #(
    parameter int unsigned W     = 10,
    parameter logic [W-1:0] FIRST = '0,
    parameter logic [W-1:0] LAST  = '1
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] step_o
);
    logic at_end;

    always_comb begin
        at_end = (val_i == LAST);
        step_o = at_end ? FIRST : val_i + W'(1);
    end
endmodule

// File: rtl/gcnt_b2g.sv
// Binary to reflected Gray conversion, one XOR per bit
module gcnt_b2g #(
    parameter int unsigned W = 10
) (
    input  logic [W-1:0] bin_i,
    output logic [W-1:0] gray_o
);
    genvar i;
    generate
        for (i = 0; i < W - 1; i++) begin : g_bit
            assign gray_o[i] = bin_i[i] ^ bin_i[i+1];
        end
    endgenerate
    assign gray_o[W-1] = bin_i[W-1];
endmodule

// File: rtl/gray_ring_counter.sv
module gray_ring_counter
    import gcnt_pkg::*;
#(
    parameter int unsigned MODULUS = 688,
    localparam int unsigned W = ptr_width(MODULUS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    output logic [W-1:0] cur_bin_o,
    output logic [W-1:0] cur_gray_o,
    output logic [W-1:0] nxt_bin_o,
    output logic [W-1:0] nxt_gray_o,
    output logic [W-1:0] nxt2_bin_o,
    output logic [W-1:0] nxt2_gray_o
);
    // Window limits and reset image of the three-stage pipeline
    localparam int unsigned FIRST_I = range_first(MODULUS);
    localparam int unsigned LAST_I  = range_last(MODULUS);
    localparam int unsigned RST1_I  = ring_step(FIRST_I, MODULUS);
    localparam int unsigned RST2_I  = ring_step(RST1_I, MODULUS);

    localparam logic [W-1:0] FIRST  = W'(FIRST_I);
    localparam logic [W-1:0] LAST   = W'(LAST_I);
    localparam logic [W-1:0] RST0_B = W'(FIRST_I);
    localparam logic [W-1:0] RST1_B = W'(RST1_I);
    localparam logic [W-1:0] RST2_B = W'(RST2_I);
    localparam logic [W-1:0] RST0_G = W'(gray32(FIRST_I));
    localparam logic [W-1:0] RST1_G = W'(gray32(RST1_I));
    localparam logic [W-1:0] RST2_G = W'(gray32(RST2_I));

    // Elaboration guard: the single-bit wrap needs an even modulus that fits
    generate
        if ((MODULUS % 2) != 0 || MODULUS < 2 || MODULUS > (32'd1 << W)) begin : g_bad_modulus
            $error("gray_ring_counter: MODULUS must be even, >= 2 and <= 2^W");
        end
    endgenerate

    typedef struct packed {
        logic [W-1:0] cur_bin;
        logic [W-1:0] nxt_bin;
        logic [W-1:0] nxt2_bin;
        logic [W-1:0] cur_gray;
        logic [W-1:0] nxt_gray;
        logic [W-1:0] nxt2_gray;
    } ptr_state_t;

    localparam ptr_state_t RST_STATE = '{
        cur_bin:   RST0_B,
        nxt_bin:   RST1_B,
        nxt2_bin:  RST2_B,
        cur_gray:  RST0_G,
        nxt_gray:  RST1_G,
        nxt2_gray: RST2_G
    };

    ptr_state_t st_d, st_q;
    logic [W-1:0] far_bin_d;
    logic [W-1:0] far_gray_d;

    // Only the two-ahead value is stepped and wrapped
    gcnt_step #(
        .W     (W),
        .FIRST (FIRST),
        .LAST  (LAST)
    ) i_far_step (
        .val_i  (st_q.nxt2_bin),
        .step_o (far_bin_d)
    );

    gcnt_b2g #(
        .W (W)
    ) i_far_gray (
        .bin_i  (far_bin_d),
        .gray_o (far_gray_d)
    );

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            st_d.cur_bin   = st_q.nxt_bin;
            st_d.nxt_bin   = st_q.nxt2_bin;
            st_d.nxt2_bin  = far_bin_d;
            st_d.cur_gray  = st_q.nxt_gray;
            st_d.nxt_gray  = st_q.nxt2_gray;
            st_d.nxt2_gray = far_gray_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_bin_o   = st_q.cur_bin;
    assign nxt_bin_o   = st_q.nxt_bin;
    assign nxt2_bin_o  = st_q.nxt2_bin;
    assign cur_gray_o  = st_q.cur_gray;
    assign nxt_gray_o  = st_q.nxt_gray;
    assign nxt2_gray_o = st_q.nxt2_gray;

endmodule

// File: rtl/gray_ring_counter_chk.sv
module gray_ring_counter_chk
    import gcnt_pkg::*;
#(
    parameter int unsigned MODULUS = 688,
    localparam int unsigned W = ptr_width(MODULUS)
) (
    input logic         clk,
    input logic         rst_n,
    input logic         adv_i,
    input logic [W-1:0] cur_bin_o,
    input logic [W-1:0] cur_gray_o,
    input logic [W-1:0] nxt_bin_o,
    input logic [W-1:0] nxt_gray_o,
    input logic [W-1:0] nxt2_bin_o,
    input logic [W-1:0] nxt2_gray_o
);
    localparam logic [W-1:0] FIRST = W'(range_first(MODULUS));
    localparam logic [W-1:0] LAST  = W'(range_last(MODULUS));

    // R2: idle edge leaves all outputs unchanged
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> ($stable(cur_bin_o) && $stable(nxt_bin_o) && $stable(nxt2_bin_o)
                    && $stable(cur_gray_o) && $stable(nxt_gray_o) && $stable(nxt2_gray_o)));

    // R3: advancing moves the pipeline forward by one stage
    p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> (cur_bin_o == $past(nxt_bin_o) && nxt_bin_o == $past(nxt2_bin_o)));

    // R4: the end of the window wraps to its start
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && cur_bin_o == LAST) |=> (cur_bin_o == FIRST));

    // R5: all pointers stay inside the window
    p_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_bin_o >= FIRST && cur_bin_o <= LAST
         && nxt_bin_o >= FIRST && nxt_bin_o <= LAST
         && nxt2_bin_o >= FIRST && nxt2_bin_o <= LAST));

    // R6: registered Gray outputs agree with their binary partners
    p_gray_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_gray_o == (cur_bin_o ^ (cur_bin_o >> 1))
         && nxt_gray_o == (nxt_bin_o ^ (nxt_bin_o >> 1))
         && nxt2_gray_o == (nxt2_bin_o ^ (nxt2_bin_o >> 1))));

    // R7: one Gray bit flips per advance
    p_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> ($countones(cur_gray_o ^ $past(cur_gray_o)) == 1));

    // R8: lookahead values sit one and two steps past the current value
    p_lookahead_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_bin_o == ((cur_bin_o == LAST) ? FIRST : cur_bin_o + W'(1))
         && nxt2_bin_o == ((nxt_bin_o == LAST) ? FIRST : nxt_bin_o + W'(1))));

endmodule

bind gray_ring_counter gray_ring_counter_chk #(
    .MODULUS (MODULUS)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv_i       (adv_i),
    .cur_bin_o   (cur_bin_o),
    .cur_gray_o  (cur_gray_o),
    .nxt_bin_o   (nxt_bin_o),
    .nxt_gray_o  (nxt_gray_o),
    .nxt2_bin_o  (nxt2_bin_o),
    .nxt2_gray_o (nxt2_gray_o)
);

// File: tb/test_gray_ring_counter.sv
`timescale 1ns/1ps
module test_gray_ring_counter;

    localparam int unsigned M     = 688;
    localparam int unsigned W     = 10;
    localparam int unsigned FIRST = (1 << (W - 1)) - M / 2;   // 168
    localparam int unsigned LAST  = FIRST + M - 1;            // 855

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         adv_i = 1'b0;
    logic [W-1:0] cur_bin_o, cur_gray_o, nxt_bin_o, nxt_gray_o, nxt2_bin_o, nxt2_gray_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gray_ring_counter #(.MODULUS(M)) i_gray_ring_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (adv_i),
        .cur_bin_o   (cur_bin_o),
        .cur_gray_o  (cur_gray_o),
        .nxt_bin_o   (nxt_bin_o),
        .nxt_gray_o  (nxt_gray_o),
        .nxt2_bin_o  (nxt2_bin_o),
        .nxt2_gray_o (nxt2_gray_o)
    );

    // Stimulus table: run length with adv_i high, then expected current value
    typedef struct packed {
        int unsigned steps;
        int unsigned want;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t TBL [NVEC] = '{
        '{0,   168}, '{1,   169}, '{10,  179}, '{676, 855}, '{1,   168},
        '{687, 855}, '{1,   168}, '{688, 168}, '{344, 512}, '{344, 168},
        '{2,   170}
    };

    function automatic int unsigned mstep(input int unsigned x);
        return (x == LAST) ? FIRST : x + 1;
    endfunction

    function automatic int unsigned mgray(input int unsigned x);
        return x ^ (x >> 1);
    endfunction

    task automatic chk(input string req, input int unsigned act, input int unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Full port comparison against the model value of the current pointer
    task automatic chk_all(input string req, input int unsigned m);
        int unsigned m1, m2;
        m1 = mstep(m);
        m2 = mstep(m1);
        chk({req, " cur_bin"},   int'(cur_bin_o),   m);
        chk({req, " nxt_bin"},   int'(nxt_bin_o),   m1);
        chk({req, " nxt2_bin"},  int'(nxt2_bin_o),  m2);
        chk({req, " cur_gray"},  int'(cur_gray_o),  mgray(m));
        chk({req, " nxt_gray"},  int'(nxt_gray_o),  mgray(m1));
        chk({req, " nxt2_gray"}, int'(nxt2_gray_o), mgray(m2));
    endtask

    // Drive at the falling edge, let one rising edge pass, sample at the next falling edge
    task automatic tick(input logic adv);
        adv_i = adv;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        int unsigned model;
        int unsigned prev_gray;

        @(negedge clk);
        @(negedge clk);
        chk_all("R1 during reset", FIRST);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 after release", FIRST);
        model = FIRST;

        for (int v = 0; v < NVEC; v++) begin
            for (int s = 0; s < int'(TBL[v].steps); s++) begin
                prev_gray = cur_gray_o;
                tick(1'b1);
                model = mstep(model);
                chk("R3 advance", int'(cur_bin_o), model);
                chk("R7 single gray bit", $countones(prev_gray ^ int'(cur_gray_o)), 1);
                chk("R5 in range", int'(cur_bin_o >= FIRST && cur_bin_o <= LAST), 1);
                chk("R6 gray form", int'(cur_gray_o), mgray(int'(cur_bin_o)));
                chk("R8 lookahead", int'(nxt2_bin_o), mstep(mstep(model)));
            end
            chk("R3 table end", int'(cur_bin_o), TBL[v].want);
            // R2: idle cycles between runs
            for (int h = 0; h < 3; h++) begin
                tick(1'b0);
                chk_all("R2 hold", TBL[v].want);
            end
        end

        // R4: approach the end and wrap once more with full port check
        while (int'(cur_bin_o) != LAST - 1) tick(1'b1);
        chk_all("R4 before end", LAST - 1);
        tick(1'b1);
        chk_all("R4 at end", LAST);
        prev_gray = cur_gray_o;
        tick(1'b1);
        chk_all("R4 wrapped", FIRST);
        chk("R7 wrap gray bits", $countones(prev_gray ^ int'(cur_gray_o)), 1);
        chk("R7 wrap top bit", (prev_gray ^ int'(cur_gray_o)), 1 << (W - 1));

        // R1: reset mid-lap reloads the window start
        repeat (100) tick(1'b1);
        chk_all("R1 mid-lap", FIRST + 100);
        adv_i = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk_all("R1 reset while advancing", FIRST);
        adv_i = 1'b0;
        rst_n = 1'b1;
        tick(1'b0);
        chk_all("R1 after second release", FIRST);
        tick(1'b1);
        chk_all("R3 first step after reset", FIRST + 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule